// File: doc/BRIEF.md
# 100 Mbps Link Integrity Monitor

This block decides whether a 100 Mbps receive link is usable. It watches a stream of decoded receive symbols. Each symbol is marked valid for one clock and carries two flags: one says the symbol is idle, the other says it is in error. From this stream the block keeps a link-status level. It also gives a one-cycle strobe each time that level changes. The decoding, descrambling and speed negotiation that feed the stream are done elsewhere.

Two drop algorithms are available, and a single mode input chooses between them. In the threshold mode (mode input low, the reset choice), the symbol stream is cut into back-to-back blocks of `BLK_LEN` valid symbols. The link falls when the errored symbols inside one block reach `ERR_LIMIT`. In the idle-watch mode (mode input high), a timer counts clock cycles. It restarts whenever `IDLE_RUN` clean idle symbols arrive in a row. If the timer reaches `TMO_LIMIT` cycles, the link falls; the default limit is 1.5 ms of a 125 MHz clock. Neither mode affects how the link comes back: that always takes `UP_RUN` clean idle symbols in a row. A change of the mode input wipes the counters of both drop algorithms.

Top module: `link_integrity_mon`

## Requirements
- R1: While reset is applied and just after it, `link_up_o` is 0 and `link_chg_o` is 0.
- R2: In threshold mode with the link up, the link stays up through 64 errored valid symbols of one block. It falls on the valid errored symbol that brings the block's count to 65 (`ERR_LIMIT`): `link_up_o` is 0 one clock after that symbol is presented.
- R3: Blocks are consecutive and do not overlap. Each holds 1024 valid symbols, counted from the first valid symbol after the link rose. Errors from one block never add to the next. An error on the 1024th symbol of a block still counts toward that block.
- R4: In idle-watch mode with the link up, a clean idle symbol is one with valid=1, idle=1 and err=0. The link falls on the `TMO_LIMIT`-th clock edge after the link rose, or after the last run of 12 (`IDLE_RUN`) consecutive clean idle symbols completed. Any other valid symbol breaks the run. An errored symbol on its own never drops the link in this mode. A run that completes on the same edge as the timeout keeps the link up.
- R5: While the link is down, it rises one clock after the `UP_RUN`-th consecutive clean idle symbol, in either mode. Any other valid symbol restarts that count.
- R6: `link_chg_o` is 1 for exactly the one cycle in which `link_up_o` shows a new value, and 0 otherwise.
- R7: A cycle in which the mode input differs from its value in the previous cycle clears the error and symbol counts, the idle run and the timer. The link cannot fall in that cycle.
- R8: Cycles with valid=0 are ignored by every counter except the idle-watch timer, whatever the idle and err flags carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_enh_i | input | 1 | 0 = error-threshold mode, 1 = idle-watch mode |
| sym_valid_i | input | 1 | A decoded symbol is present this cycle |
| sym_idle_i | input | 1 | The present symbol is an idle symbol |
| sym_err_i | input | 1 | The present symbol was received in error |
| link_up_o | output | 1 | Link status level, 1 = up |
| link_chg_o | output | 1 | One-cycle pulse on each change of link_up_o |

## Verification
Two pairs of functions can land on the same clock edge. In threshold mode, the edge that closes a 1024-symbol block is also the edge that clears the error count. In idle-watch mode, a completing idle run can arrive on the very edge the timeout expires. The bench provokes the first by putting 64 errors early in a block and the 65th error exactly on the block's last symbol; the link must fall. It provokes the second by timing a 12-idle run to end on the expiry edge; the link must stay up, and must then fall a full timeout later. A third collision, a mode change together with the error that would be the 65th, must leave the link up.

// File: rtl/lim_pkg.sv
package lim_pkg;

  typedef enum logic {
    LINK_DOWN = 1'b0,
    LINK_UP   = 1'b1
  } link_state_e;

  typedef struct packed {
    logic valid;
    logic idle;
    logic err;
  } sym_t;

  function automatic logic clean_idle(input sym_t s);
    return s.valid & s.idle & ~s.err;
  endfunction

endpackage

// File: rtl/lim_rst_sync.sv
module lim_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_many
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lim_err_rate.sv
module lim_err_rate #(
  parameter int BLK_LEN   = 1024,
  parameter int ERR_LIMIT = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic clr_i,
  input  logic valid_i,
  input  logic err_i,
  output logic drop_o
);

  localparam int SW = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;
  localparam int EW = $clog2(ERR_LIMIT + 1);
  localparam logic [SW-1:0] LAST_IDX  = SW'(BLK_LEN - 1);
  localparam logic [EW-1:0] ERR_LIM_W = EW'(ERR_LIMIT);

  logic [SW-1:0] sym_cnt_q, sym_cnt_d;
  logic [EW-1:0] err_cnt_q, err_cnt_d;
  logic          cnt_upd;
  logic          active;
  logic          blk_last;
  logic [EW-1:0] err_sum;

  always_comb begin
    active   = en_i & ~clr_i;
    blk_last = (sym_cnt_q == LAST_IDX);
    err_sum  = err_cnt_q + EW'(err_i);
    drop_o   = active & valid_i & err_i & (err_sum >= ERR_LIM_W);

    cnt_upd   = 1'b0;
    sym_cnt_d = sym_cnt_q;
    err_cnt_d = err_cnt_q;
    if (!active) begin
      cnt_upd   = 1'b1;
      sym_cnt_d = '0;
      err_cnt_d = '0;
    end else if (valid_i) begin
      cnt_upd = 1'b1;
      if (blk_last) begin
        sym_cnt_d = '0;
        err_cnt_d = '0;
      end else begin
        sym_cnt_d = sym_cnt_q + 1'b1;
        err_cnt_d = err_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_cnt_q <= '0;
      err_cnt_q <= '0;
    end else if (cnt_upd) begin
      sym_cnt_q <= sym_cnt_d;
      err_cnt_q <= err_cnt_d;
    end
  end

endmodule

// File: rtl/lim_idle_watch.sv
module lim_idle_watch
  import lim_pkg::*;
#(
  parameter int IDLE_RUN  = 12,
  parameter int TMO_LIMIT = 187500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic clr_i,
  input  sym_t sym_i,
  output logic drop_o
);

  localparam int RW = $clog2(IDLE_RUN + 1);
  localparam int TW = (TMO_LIMIT > 1) ? $clog2(TMO_LIMIT) : 1;
  localparam logic [RW-1:0] RUN_END = RW'(IDLE_RUN - 1);
  localparam logic [TW-1:0] TMO_END = TW'(TMO_LIMIT - 1);

  logic [RW-1:0] run_q, run_d;
  logic [TW-1:0] tmo_q, tmo_d;
  logic          run_upd;
  logic          tmo_upd;
  logic          active;
  logic          good;
  logic          restart;
  logic          expired;

  always_comb begin
    active  = en_i & ~clr_i;
    good    = clean_idle(sym_i);
    restart = active & good & (run_q == RUN_END);
    expired = (tmo_q == TMO_END);
    drop_o  = active & ~restart & expired;

    run_upd = 1'b0;
    run_d   = run_q;
    if (!active) begin
      run_upd = 1'b1;
      run_d   = '0;
    end else if (sym_i.valid) begin
      run_upd = 1'b1;
      if (good && !restart) run_d = run_q + 1'b1;
      else                  run_d = '0;
    end

    tmo_upd = 1'b0;
    tmo_d   = tmo_q;
    if (!active || restart) begin
      tmo_upd = 1'b1;
      tmo_d   = '0;
    end else if (!expired) begin
      tmo_upd = 1'b1;
      tmo_d   = tmo_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (run_upd) run_q <= run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tmo_q <= '0;
    else if (tmo_upd) tmo_q <= tmo_d;
  end

endmodule

// File: rtl/lim_link_fsm.sv
module lim_link_fsm
  import lim_pkg::*;
#(
  parameter int UP_RUN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  sym_t sym_i,
  input  logic drop_i,
  output logic link_up_o,
  output logic link_chg_o
);

  localparam int UW = $clog2(UP_RUN + 1);
  localparam logic [UW-1:0] UP_END = UW'(UP_RUN - 1);

  link_state_e   state_q, state_d;
  logic [UW-1:0] up_cnt_q, up_cnt_d;
  logic          up_upd;
  logic          chg_q, chg_d;
  logic          good;
  logic          rise;

  always_comb begin
    good = clean_idle(sym_i);
    rise = (state_q == LINK_DOWN) & good & (up_cnt_q == UP_END);

    state_d = state_q;
    unique case (state_q)
      LINK_DOWN: if (rise)   state_d = LINK_UP;
      LINK_UP:   if (drop_i) state_d = LINK_DOWN;
      default:   state_d = LINK_DOWN;
    endcase
    chg_d = (state_d != state_q);

    up_upd   = 1'b0;
    up_cnt_d = up_cnt_q;
    if (state_q == LINK_UP || rise) begin
      up_upd   = (up_cnt_q != '0);
      up_cnt_d = '0;
    end else if (sym_i.valid) begin
      up_upd   = 1'b1;
      up_cnt_d = good ? up_cnt_q + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LINK_DOWN;
      chg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      chg_q   <= chg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      up_cnt_q <= '0;
    else if (up_upd) up_cnt_q <= up_cnt_d;
  end

  assign link_up_o  = (state_q == LINK_UP);
  assign link_chg_o = chg_q;

endmodule

// File: rtl/link_integrity_mon.sv
module link_integrity_mon
  import lim_pkg::*;
#(
  parameter int BLK_LEN     = 1024,
  parameter int ERR_LIMIT   = 65,
  parameter int IDLE_RUN    = 12,
  parameter int TMO_LIMIT   = 187500,
  parameter int UP_RUN      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_enh_i,
  input  logic sym_valid_i,
  input  logic sym_idle_i,
  input  logic sym_err_i,
  output logic link_up_o,
  output logic link_chg_o
);

  logic rst_int_n;
  logic mode_q;
  logic mode_flip;
  logic std_en;
  logic enh_en;
  logic std_drop;
  logic enh_drop;
  logic drop;
  logic link_up;
  sym_t sym;

  lim_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_int_n)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) mode_q <= 1'b0;
    else            mode_q <= mode_enh_i;
  end

  always_comb begin
    sym       = '{valid: sym_valid_i, idle: sym_idle_i, err: sym_err_i};
    mode_flip = (mode_enh_i != mode_q);
    std_en    = link_up & ~mode_enh_i;
    enh_en    = link_up &  mode_enh_i;
    drop      = mode_enh_i ? enh_drop : std_drop;
  end

  lim_err_rate #(
    .BLK_LEN   (BLK_LEN),
    .ERR_LIMIT (ERR_LIMIT)
  ) u_err_rate (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en_i    (std_en),
    .clr_i   (mode_flip),
    .valid_i (sym_valid_i),
    .err_i   (sym_err_i),
    .drop_o  (std_drop)
  );

  lim_idle_watch #(
    .IDLE_RUN  (IDLE_RUN),
    .TMO_LIMIT (TMO_LIMIT)
  ) u_idle_watch (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en_i   (enh_en),
    .clr_i  (mode_flip),
    .sym_i  (sym),
    .drop_o (enh_drop)
  );

  lim_link_fsm #(.UP_RUN(UP_RUN)) u_link_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sym_i      (sym),
    .drop_i     (drop),
    .link_up_o  (link_up),
    .link_chg_o (link_chg_o)
  );

  assign link_up_o = link_up;

endmodule

// File: rtl/lim_checker.sv
module lim_checker (
  input logic clk,
  input logic rst_n,
  input logic mode_enh_i,
  input logic sym_valid_i,
  input logic sym_idle_i,
  input logic sym_err_i,
  input logic link_up_o,
  input logic link_chg_o
);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R6: strobe high exactly when the level differs from the previous cycle
  p_strobe_marks_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (link_chg_o == (link_up_o != $past(link_up_o))));

  // R5: a rise is always caused by a clean idle symbol
  p_rise_needs_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $rose(link_up_o)) |-> $past(sym_valid_i && sym_idle_i && !sym_err_i));

  // R2: in threshold mode a fall is always caused by a valid errored symbol
  p_std_drop_needs_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $fell(link_up_o) && !$past(mode_enh_i)) |-> $past(sym_valid_i && sym_err_i));

  // R7: the cycle of a mode change never takes the link down
  p_mode_flip_keeps_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && link_up_o && (mode_enh_i != $past(mode_enh_i))) |=> link_up_o);

endmodule

bind link_integrity_mon lim_checker u_lim_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_enh_i  (mode_enh_i),
  .sym_valid_i (sym_valid_i),
  .sym_idle_i  (sym_idle_i),
  .sym_err_i   (sym_err_i),
  .link_up_o   (link_up_o),
  .link_chg_o  (link_chg_o)
);

// File: tb/link_integrity_mon_tb.sv
module link_integrity_mon_tb;

  localparam int BLK = 1024;
  localparam int ELIM = 65;
  localparam int RUN = 12;
  localparam int TMO = 300;
  localparam int UPN = 16;

  logic clk;
  logic rst_n;
  logic mode;
  logic v, i, e;
  logic link, chg;
  int   checks;
  int   failures;
  bit   done;

  link_integrity_mon #(.TMO_LIMIT(TMO)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_enh_i  (mode),
    .sym_valid_i (v),
    .sym_idle_i  (i),
    .sym_err_i   (e),
    .link_up_o   (link),
    .link_chg_o  (chg)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // present one symbol at a falling edge; returns after the rising edge consumed it
  task automatic sym(input logic sv, input logic si, input logic se);
    v = sv; i = si; e = se;
    @(negedge clk);
  endtask

  task automatic rep(input int n, input logic sv, input logic si, input logic se);
    for (int k = 0; k < n; k++) sym(sv, si, se);
  endtask

  task automatic bring_up(input string req);
    rep(UPN - 1, 1, 1, 0);
    chk(req, "link before last idle", link, 1'b0);
    sym(1, 1, 0);
    chk(req, "link after idle run", link, 1'b1);
    chk("R6", "strobe on rise", chg, 1'b1);
    sym(0, 0, 0);
    chk("R6", "strobe cleared", chg, 1'b0);
  endtask

  task automatic expect_drop(input string req);
    chk(req, "link dropped", link, 1'b0);
    chk("R6", "strobe on fall", chg, 1'b1);
    sym(0, 0, 0);
    chk("R6", "strobe cleared after fall", chg, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1", "link in reset", link, 1'b0);
    chk("R1", "strobe in reset", chg, 1'b0);
    rst_n = 1'b1;
    rep(4, 0, 0, 0);
    chk("R1", "link after reset", link, 1'b0);
    chk("R1", "strobe after reset", chg, 1'b0);
  endtask

  task automatic t_rise_rules;
    mode = 1'b0;
    rep(10, 1, 1, 0);
    sym(1, 1, 1);                 // errored idle breaks the run (R5)
    rep(5, 0, 1, 0);              // invalid cycles do not count (R8)
    rep(UPN - 1, 1, 1, 0);
    chk("R5", "still down after broken run", link, 1'b0);
    chk("R6", "no strobe without change", chg, 1'b0);
    for (int k = 0; k < 3; k++) sym(0, 1, 1);  // invalid cycles neither count nor break (R8)
    sym(1, 1, 0);
    chk("R5", "rises on 16th clean idle", link, 1'b1);
    chk("R6", "strobe on rise", chg, 1'b1);
    sym(0, 0, 0);
    chk("R6", "strobe one cycle", chg, 1'b0);
  endtask

  task automatic t_std_threshold;
    rep(ELIM - 1, 1, 0, 1);
    chk("R2", "up at 64 errors", link, 1'b1);
    rep(10, 0, 0, 1);
    chk("R8", "invalid errors ignored", link, 1'b1);
    sym(1, 0, 1);
    expect_drop("R2");
  endtask

  task automatic t_std_blocks;
    bring_up("R5");
    rep(ELIM - 1, 1, 0, 1);
    rep(BLK - (ELIM - 1), 1, 0, 0);
    rep(ELIM - 1, 1, 0, 1);
    chk("R3", "errors do not carry across blocks", link, 1'b1);
    sym(1, 0, 1);
    expect_drop("R3");
  endtask

  task automatic t_std_boundary;
    bring_up("R5");
    rep(ELIM - 1, 1, 0, 1);
    rep(BLK - ELIM, 1, 0, 0);
    chk("R3", "up before last symbol of block", link, 1'b1);
    sym(1, 0, 1);
    expect_drop("R3");
  endtask

  task automatic t_mode_flip;
    mode = 1'b0;
    bring_up("R5");
    rep(ELIM - 1, 1, 0, 1);
    mode = 1'b1;
    sym(1, 0, 1);
    chk("R7", "no drop on mode change cycle", link, 1'b1);
    sym(1, 0, 0);
    mode = 1'b0;
    sym(1, 0, 0);
    rep(ELIM - 1, 1, 0, 1);
    chk("R7", "error count cleared by mode change", link, 1'b1);
    sym(1, 0, 1);
    expect_drop("R7");
    mode = 1'b1;
    bring_up("R5");
    rep(TMO - 3, 1, 0, 0);
    mode = 1'b0;
    sym(1, 0, 0);
    mode = 1'b1;
    sym(1, 0, 0);
    rep(TMO - 1, 1, 0, 0);
    chk("R7", "timer cleared by mode change", link, 1'b1);
    sym(1, 0, 0);
    expect_drop("R7");
  endtask

  task automatic t_enh_timeout;
    mode = 1'b1;
    bring_up("R5");
    rep(TMO - 2, 1, 0, 0);
    chk("R4", "up before timeout", link, 1'b1);
    sym(1, 0, 0);
    expect_drop("R4");
  endtask

  task automatic t_enh_refresh;
    mode = 1'b1;
    bring_up("R5");
    rep(100, 1, 0, 1);
    chk("R4", "errors alone do not drop", link, 1'b1);
    rep(50 * RUN, 1, 1, 0);
    chk("R4", "idle runs keep link", link, 1'b1);
    rep(TMO - 1, 1, 0, 0);
    chk("R4", "up one cycle before timeout", link, 1'b1);
    sym(1, 0, 0);
    expect_drop("R4");
  endtask

  task automatic t_enh_broken_runs;
    mode = 1'b1;
    bring_up("R5");
    rep(100, 1, 0, 1);
    for (int k = 0; k < 198; k++) sym(1, (k % RUN) != (RUN - 1), 1'b0);
    chk("R4", "up before timeout with broken runs", link, 1'b1);
    sym(1, 1, 0);
    expect_drop("R4");
  endtask

  task automatic t_enh_coincide;
    mode = 1'b1;
    bring_up("R5");
    rep(TMO - 1 - RUN, 1, 0, 0);
    rep(RUN, 1, 1, 0);
    chk("R4", "run on expiry edge keeps link", link, 1'b1);
    chk("R6", "no strobe on coincidence", chg, 1'b0);
    rep(TMO - 1, 1, 0, 0);
    chk("R4", "up before next timeout", link, 1'b1);
    sym(1, 0, 0);
    expect_drop("R4");
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; mode = 1'b0; v = 1'b0; i = 1'b0; e = 1'b0;
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_rise_rules();
    t_std_threshold();
    t_std_blocks();
    t_std_boundary();
    t_mode_flip();
    t_enh_timeout();
    t_enh_refresh();
    t_enh_broken_runs();
    t_enh_coincide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule